// File: doc/BRIEF.md
# Chained-Descriptor 2D Word DMA Channel

This block is one DMA channel that follows a chain of transfer descriptors kept in system memory. Software writes descriptors, raises `start` with the address of the first one, and the channel works through the chain. For each descriptor it reads the six descriptor words, then copies 32-bit words from a source area to a destination area. It then flags completion and follows the descriptor's link word. The chain ends at a zero link or when `enable` is low at a descriptor boundary.

A copy is either one linear run of bytes or a 2D block of rows. In the 2D case a signed source step and a signed destination step are added between rows. Either side can hold its address fixed or step it by one word per beat. Either side can also be turned off: skipping the source writes zeros, and skipping the destination performs reads with no stores. All memory traffic goes through one word-wide request port with a valid/ready handshake, and only one request is in flight at a time. A read finishes when its response is returned.

The controller is a single state machine with these states:
- `ST_IDLE`: waits for `start`.
- `ST_LINK`: decides whether to fetch another descriptor.
- `ST_FETCH_REQ` and `ST_FETCH_RSP`: fetch one descriptor word per pass.
- `ST_DECODE`: derives rows, row bytes and steps.
- `ST_BEAT_CHK`: picks the next action.
- `ST_RD_REQ` and `ST_RD_RSP`: the source read.
- `ST_WR_REQ`: the destination write.
- `ST_BEAT_ADV`: moves the addresses and counts down.
- `ST_ROW_END`: applies the steps between rows.
- `ST_DESC_END`: flags completion and loads the link.

The transitions are:
- `ST_IDLE` goes to `ST_LINK` on `start`.
- `ST_LINK` goes to `ST_FETCH_REQ` when enabled with a nonzero descriptor address, and otherwise to `ST_IDLE`.
- `ST_FETCH_REQ` goes to `ST_FETCH_RSP` on `mem_ready`.
- `ST_FETCH_RSP` goes back to `ST_FETCH_REQ` on `mem_rvalid`, or to `ST_DECODE` after the sixth word.
- `ST_DECODE` goes to `ST_BEAT_CHK`.
- `ST_BEAT_CHK` goes to one of four states:
  - `ST_DESC_END` when no rows remain.
  - `ST_ROW_END` when the row is empty.
  - `ST_RD_REQ` for a normal beat.
  - `ST_WR_REQ` or `ST_BEAT_ADV` when the source is skipped.
- `ST_RD_REQ` goes to `ST_RD_RSP` on `mem_ready`.
- `ST_RD_RSP` goes to `ST_WR_REQ`, or to `ST_BEAT_ADV` when the destination is skipped.
- `ST_WR_REQ` goes to `ST_BEAT_ADV` on `mem_ready`.
- `ST_BEAT_ADV` goes to `ST_BEAT_CHK`.
- `ST_ROW_END` goes to `ST_BEAT_CHK`, or to `ST_DESC_END` after the last row.
- `ST_DESC_END` goes to `ST_LINK`.

Top module: `dma2d_engine`

## Requirements
- R1: After reset the channel is inactive: `active`=0, `halted`=0, `end_flag`=0, `irq`=0 and `mem_valid`=0.
- R2: Each descriptor is fetched as six word reads at its address plus 0, 4, 8, 12, 16 and 20, in that order. The six words are: control word, source address, destination address, length word, step word and link address.
- R3: Control bits decide the linear copy. When control bit 1 is 0, the whole length word is a byte count, and each beat moves one word and lowers the count by 4. Bit 8 makes the source address and bit 4 makes the destination address advance by 4 per beat; a clear bit holds that address.
- R4: When control bit 1 is 1, length bits 29:16 give the row count and length bits 15:0 give the bytes per row. The per-row byte count is reloaded for each row. A row count of zero moves no data.
- R5: In 2D mode, step-word bits 31:16 are a signed destination step and bits 15:0 a signed source step. They are added after every row except the last.
- R6: When control bit 11 is set, no source read is issued and the destination receives zero. The source address still follows its increment bit.
- R7: When control bit 7 is set, no destination write is issued, while the destination address still advances per its increment bit.
- R8: `cur_len` shows the remaining work. In linear mode it is the remaining byte count. In 2D mode it holds the remaining rows in bits 29:16 and the remaining bytes of the row in bits 15:0.
- R9: Each completed descriptor sets `end_flag`, and also sets `irq` when control bit 0 is 1. `end_clr` and `int_clr` clear them, but a completion in the same cycle wins over the clear.
- R10: On completion the link word becomes the current descriptor address. Processing continues while `enable` is high and that address is nonzero. Enable is sampled only at descriptor boundaries.
- R11: When the chain stops, `active` falls and `halted` rises. `start` clears `halted`. `start` is ignored while `active` is high. Starting at address zero, or while disabled, moves nothing.
- R12: A request holds `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` steady until `mem_ready`. No new request is raised while a read response is outstanding. `mem_addr` bits 1:0 are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Channel enable, sampled at descriptor boundaries |
| start | input | 1 | Begin a chain at `start_addr` (ignored while active) |
| start_addr | input | ADDR_W | Address of the first descriptor |
| end_clr | input | 1 | Clear request for `end_flag` |
| int_clr | input | 1 | Clear request for `irq` |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | ADDR_W | Word-aligned request address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| active | output | 1 | Channel busy with a chain |
| halted | output | 1 | Chain finished or refused; cleared by start |
| end_flag | output | 1 | At least one descriptor completed |
| irq | output | 1 | Interrupt from a descriptor with its interrupt bit set |
| cur_desc | output | ADDR_W | Current descriptor address |
| cur_src | output | ADDR_W | Live source address |
| cur_dst | output | ADDR_W | Live destination address |
| cur_len | output | 32 | Live remaining-length word |

## Verification
Descriptor completion can land in the same cycle as a software clear of `end_flag` or `irq`. The order in which the two are resolved decides whether an interrupt is lost. The bench provokes this by holding `end_clr` and `int_clr` high for a whole run of an interrupt-enabled descriptor. The set must win, so each flag is seen high for exactly one cycle, after which the held clear removes it. A design that gave the clear priority would never show the flag, and a design that ignored the clear would keep it up past that one cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 6;
    localparam int IDX_W      = $clog2(DESC_WORDS);
    localparam int ROW_W      = 14;
    localparam int BEAT_BYTES = 4;

    // control-word bit positions
    localparam int B_IRQ_EN   = 0;
    localparam int B_MODE_2D  = 1;
    localparam int B_DST_INC  = 4;
    localparam int B_DST_SKIP = 7;
    localparam int B_SRC_INC  = 8;
    localparam int B_SRC_SKIP = 11;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LINK,
        ST_FETCH_REQ,
        ST_FETCH_RSP,
        ST_DECODE,
        ST_BEAT_CHK,
        ST_RD_REQ,
        ST_RD_RSP,
        ST_WR_REQ,
        ST_BEAT_ADV,
        ST_ROW_END,
        ST_DESC_END
    } state_t;

    typedef enum logic [1:0] {
        SEL_DESC,
        SEL_SRC,
        SEL_DST
    } sel_t;

    typedef struct packed {
        logic irq_en;
        logic mode_2d;
        logic dst_inc;
        logic dst_skip;
        logic src_inc;
        logic src_skip;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.irq_en   = w[B_IRQ_EN];
        c.mode_2d  = w[B_MODE_2D];
        c.dst_inc  = w[B_DST_INC];
        c.dst_skip = w[B_DST_SKIP];
        c.src_inc  = w[B_SRC_INC];
        c.src_skip = w[B_SRC_SKIP];
        return c;
    endfunction

endpackage

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
    import dma2d_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   enable,
    input  logic   start,
    input  logic   desc_nz,
    input  logic   fetch_last,
    input  ctl_t   ctl,
    input  logic   rows_zero,
    input  logic   bytes_zero,
    input  logic   rows_last,
    input  logic   mem_ready,
    input  logic   mem_rvalid,
    output logic   mem_valid,
    output logic   mem_write,
    output sel_t   mem_sel,
    output logic   do_start_ld,
    output logic   do_fetch_clr,
    output logic   do_fetch_ld,
    output logic   do_decode,
    output logic   do_zero_data,
    output logic   do_rd_ld,
    output logic   do_beat_adv,
    output logic   do_row_adv,
    output logic   do_desc_done,
    output logic   active,
    output logic   halted
);

    state_t st, nxt;
    logic   go_on;

    assign go_on = enable && desc_nz;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE:      if (start) nxt = ST_LINK;
            ST_LINK:      nxt = go_on ? ST_FETCH_REQ : ST_IDLE;
            ST_FETCH_REQ: if (mem_ready) nxt = ST_FETCH_RSP;
            ST_FETCH_RSP: if (mem_rvalid) nxt = fetch_last ? ST_DECODE : ST_FETCH_REQ;
            ST_DECODE:    nxt = ST_BEAT_CHK;
            ST_BEAT_CHK: begin
                if (rows_zero)         nxt = ST_DESC_END;
                else if (bytes_zero)   nxt = ST_ROW_END;
                else if (ctl.src_skip) nxt = ctl.dst_skip ? ST_BEAT_ADV : ST_WR_REQ;
                else                   nxt = ST_RD_REQ;
            end
            ST_RD_REQ:    if (mem_ready) nxt = ST_RD_RSP;
            ST_RD_RSP:    if (mem_rvalid) nxt = ctl.dst_skip ? ST_BEAT_ADV : ST_WR_REQ;
            ST_WR_REQ:    if (mem_ready) nxt = ST_BEAT_ADV;
            ST_BEAT_ADV:  nxt = ST_BEAT_CHK;
            ST_ROW_END:   nxt = rows_last ? ST_DESC_END : ST_BEAT_CHK;
            ST_DESC_END:  nxt = ST_LINK;
            default:      nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_valid    = 1'b0;
        mem_write    = 1'b0;
        mem_sel      = SEL_DESC;
        do_start_ld  = 1'b0;
        do_fetch_clr = 1'b0;
        do_fetch_ld  = 1'b0;
        do_decode    = 1'b0;
        do_zero_data = 1'b0;
        do_rd_ld     = 1'b0;
        do_beat_adv  = 1'b0;
        do_row_adv   = 1'b0;
        do_desc_done = 1'b0;
        unique case (st)
            ST_IDLE:      do_start_ld = start;
            ST_LINK:      do_fetch_clr = 1'b1;
            ST_FETCH_REQ: begin
                mem_valid = 1'b1;
                mem_sel   = SEL_DESC;
            end
            ST_FETCH_RSP: do_fetch_ld = mem_rvalid;
            ST_DECODE:    do_decode = 1'b1;
            ST_BEAT_CHK:  do_zero_data = !rows_zero && !bytes_zero && ctl.src_skip;
            ST_RD_REQ: begin
                mem_valid = 1'b1;
                mem_sel   = SEL_SRC;
            end
            ST_RD_RSP:    do_rd_ld = mem_rvalid;
            ST_WR_REQ: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_sel   = SEL_DST;
            end
            ST_BEAT_ADV:  do_beat_adv = 1'b1;
            ST_ROW_END:   do_row_adv = 1'b1;
            ST_DESC_END:  do_desc_done = 1'b1;
            default: ;
        endcase
    end

    assign active = (st != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       halted <= 1'b0;
        else if (st == ST_IDLE && start)  halted <= 1'b0;
        else if (st == ST_LINK && !go_on) halted <= 1'b1;
    end

    // R11
    busy_xor_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(active && halted));

    // R12
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH_RSP || st == ST_RD_RSP) |-> !mem_valid);

endmodule

// File: rtl/dma2d_dpath.sv
module dma2d_dpath
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   start_addr,
    input  sel_t                mem_sel,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic                do_start_ld,
    input  logic                do_fetch_clr,
    input  logic                do_fetch_ld,
    input  logic                do_decode,
    input  logic                do_zero_data,
    input  logic                do_rd_ld,
    input  logic                do_beat_adv,
    input  logic                do_row_adv,
    input  logic                do_desc_done,
    output ctl_t                ctl,
    output logic                desc_nz,
    output logic                fetch_last,
    output logic                rows_zero,
    output logic                bytes_zero,
    output logic                rows_last,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [ADDR_W-1:0]   cur_desc,
    output logic [ADDR_W-1:0]   cur_src,
    output logic [ADDR_W-1:0]   cur_dst,
    output logic [WORD_W-1:0]   cur_len
);

    localparam int HALF_W = WORD_W / 2;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BEAT_BYTES);

    logic [IDX_W-1:0]   fetch_idx;
    logic [WORD_W-1:0]  step_w;
    logic [ADDR_W-1:0]  link_q;
    logic [ROW_W-1:0]   rows;
    logic [WORD_W-1:0]  row_bytes;
    logic [WORD_W-1:0]  bytes_left;
    logic [WORD_W-1:0]  bytes_nxt;
    logic [ROW_W-1:0]   rows_nxt;
    logic [ADDR_W-1:0]  src_step;
    logic [ADDR_W-1:0]  dst_step;
    logic [ADDR_W-1:0]  raw_addr;

    assign bytes_nxt = bytes_left - WORD_W'(BEAT_BYTES);
    assign rows_nxt  = rows - 1'b1;
    assign src_step  = {{(ADDR_W-HALF_W){step_w[HALF_W-1]}}, step_w[HALF_W-1:0]};
    assign dst_step  = {{(ADDR_W-HALF_W){step_w[WORD_W-1]}}, step_w[WORD_W-1:HALF_W]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_idx  <= '0;
            ctl        <= '0;
            cur_desc   <= '0;
            cur_src    <= '0;
            cur_dst    <= '0;
            cur_len    <= '0;
            step_w     <= '0;
            link_q     <= '0;
            rows       <= '0;
            row_bytes  <= '0;
            bytes_left <= '0;
            mem_wdata  <= '0;
        end else begin
            if (do_start_ld)  cur_desc <= start_addr;
            if (do_fetch_clr) fetch_idx <= '0;
            if (do_fetch_ld) begin
                fetch_idx <= fetch_idx + 1'b1;
                case (fetch_idx)
                    IDX_W'(0): ctl     <= decode_ctl(mem_rdata);
                    IDX_W'(1): cur_src <= mem_rdata[ADDR_W-1:0];
                    IDX_W'(2): cur_dst <= mem_rdata[ADDR_W-1:0];
                    IDX_W'(3): cur_len <= mem_rdata;
                    IDX_W'(4): step_w  <= mem_rdata;
                    default:   link_q  <= mem_rdata[ADDR_W-1:0];
                endcase
            end
            if (do_decode) begin
                if (ctl.mode_2d) begin
                    rows       <= cur_len[HALF_W+ROW_W-1:HALF_W];
                    row_bytes  <= {{HALF_W{1'b0}}, cur_len[HALF_W-1:0]};
                    bytes_left <= {{HALF_W{1'b0}}, cur_len[HALF_W-1:0]};
                end else begin
                    rows       <= ROW_W'(1);
                    row_bytes  <= cur_len;
                    bytes_left <= cur_len;
                end
            end
            if (do_zero_data) mem_wdata <= '0;
            if (do_rd_ld)     mem_wdata <= mem_rdata;
            if (do_beat_adv) begin
                if (ctl.src_inc) cur_src <= cur_src + STEP;
                if (ctl.dst_inc) cur_dst <= cur_dst + STEP;
                bytes_left <= bytes_nxt;
                if (ctl.mode_2d)
                    cur_len <= {{(HALF_W-ROW_W){1'b0}}, rows, bytes_nxt[HALF_W-1:0]};
                else
                    cur_len <= bytes_nxt;
            end
            if (do_row_adv) begin
                rows <= rows_nxt;
                if (!rows_last) begin
                    cur_src    <= cur_src + src_step;
                    cur_dst    <= cur_dst + dst_step;
                    bytes_left <= row_bytes;
                    cur_len    <= {{(HALF_W-ROW_W){1'b0}}, rows_nxt, row_bytes[HALF_W-1:0]};
                end
            end
            if (do_desc_done) cur_desc <= link_q;
        end
    end

    always_comb begin
        unique case (mem_sel)
            SEL_SRC: raw_addr = cur_src;
            SEL_DST: raw_addr = cur_dst;
            default: raw_addr = cur_desc + ADDR_W'({fetch_idx, 2'b00});
        endcase
    end

    assign mem_addr   = {raw_addr[ADDR_W-1:2], 2'b00};
    assign desc_nz    = (cur_desc != '0);
    assign fetch_last = (fetch_idx == IDX_W'(DESC_WORDS - 1));
    assign rows_zero  = (rows == '0);
    assign bytes_zero = (bytes_left == '0);
    assign rows_last  = (rows == ROW_W'(1));

    // R2
    fetch_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_idx <= IDX_W'(DESC_WORDS));

    // R5
    last_row_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_row_adv && rows_last) |=> ($stable(cur_src) && $stable(cur_dst)));

endmodule

// File: rtl/dma2d_flags.sv
module dma2d_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic desc_done,
    input  logic irq_en,
    input  logic end_clr,
    input  logic int_clr,
    output logic end_flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_flag <= 1'b0;
            irq      <= 1'b0;
        end else begin
            if (desc_done)    end_flag <= 1'b1;
            else if (end_clr) end_flag <= 1'b0;
            if (desc_done && irq_en) irq <= 1'b1;
            else if (int_clr)        irq <= 1'b0;
        end
    end

    // R9
    set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_done && irq_en) |=> (irq && end_flag));

endmodule

// File: rtl/dma2d_engine.sv
module dma2d_engine
    import dma2d_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                start,
    input  logic [ADDR_W-1:0]   start_addr,
    input  logic                end_clr,
    input  logic                int_clr,
    output logic                mem_valid,
    output logic                mem_write,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic                mem_rvalid,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                active,
    output logic                halted,
    output logic                end_flag,
    output logic                irq,
    output logic [ADDR_W-1:0]   cur_desc,
    output logic [ADDR_W-1:0]   cur_src,
    output logic [ADDR_W-1:0]   cur_dst,
    output logic [WORD_W-1:0]   cur_len
);

    ctl_t ctl;
    sel_t mem_sel;
    logic desc_nz, fetch_last, rows_zero, bytes_zero, rows_last;
    logic do_start_ld, do_fetch_clr, do_fetch_ld, do_decode, do_zero_data;
    logic do_rd_ld, do_beat_adv, do_row_adv, do_desc_done;

    dma2d_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .start        (start),
        .desc_nz      (desc_nz),
        .fetch_last   (fetch_last),
        .ctl          (ctl),
        .rows_zero    (rows_zero),
        .bytes_zero   (bytes_zero),
        .rows_last    (rows_last),
        .mem_ready    (mem_ready),
        .mem_rvalid   (mem_rvalid),
        .mem_valid    (mem_valid),
        .mem_write    (mem_write),
        .mem_sel      (mem_sel),
        .do_start_ld  (do_start_ld),
        .do_fetch_clr (do_fetch_clr),
        .do_fetch_ld  (do_fetch_ld),
        .do_decode    (do_decode),
        .do_zero_data (do_zero_data),
        .do_rd_ld     (do_rd_ld),
        .do_beat_adv  (do_beat_adv),
        .do_row_adv   (do_row_adv),
        .do_desc_done (do_desc_done),
        .active       (active),
        .halted       (halted)
    );

    dma2d_dpath #(.ADDR_W(ADDR_W)) u_dpath (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_addr   (start_addr),
        .mem_sel      (mem_sel),
        .mem_rdata    (mem_rdata),
        .do_start_ld  (do_start_ld),
        .do_fetch_clr (do_fetch_clr),
        .do_fetch_ld  (do_fetch_ld),
        .do_decode    (do_decode),
        .do_zero_data (do_zero_data),
        .do_rd_ld     (do_rd_ld),
        .do_beat_adv  (do_beat_adv),
        .do_row_adv   (do_row_adv),
        .do_desc_done (do_desc_done),
        .ctl          (ctl),
        .desc_nz      (desc_nz),
        .fetch_last   (fetch_last),
        .rows_zero    (rows_zero),
        .bytes_zero   (bytes_zero),
        .rows_last    (rows_last),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .cur_desc     (cur_desc),
        .cur_src      (cur_src),
        .cur_dst      (cur_dst),
        .cur_len      (cur_len)
    );

    dma2d_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .desc_done (do_desc_done),
        .irq_en    (ctl.irq_en),
        .end_clr   (end_clr),
        .int_clr   (int_clr),
        .end_flag  (end_flag),
        .irq       (irq)
    );

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_write)
                                       && $stable(mem_addr) && $stable(mem_wdata)));

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !mem_valid);

    // R7
    skip_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> !ctl.dst_skip);

endmodule

// File: tb/sim_dma2d_engine.sv
module sim_dma2d_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        end_clr = 1'b0;
    logic        int_clr = 1'b0;
    logic        mem_valid, mem_write;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ready;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        active, halted, end_flag, irq;
    logic [31:0] cur_desc, cur_src, cur_dst, cur_len;

    always #2 clk = ~clk;

    dma2d_engine #(.ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
        .start_addr(start_addr), .end_clr(end_clr), .int_clr(int_clr),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .active(active), .halted(halted),
        .end_flag(end_flag), .irq(irq), .cur_desc(cur_desc), .cur_src(cur_src),
        .cur_dst(cur_dst), .cur_len(cur_len)
    );

    // behavioural memory with random stalls
    logic [31:0] mem [0:1023];
    logic        tb_we = 1'b0;
    logic [9:0]  tb_wa = '0;
    logic [31:0] tb_wd = '0;
    int          rd_cnt = 0, wr_cnt = 0, viol = 0;
    logic [31:0] rd_log [0:255];
    logic        pend, prev_wait, prev_write;
    logic [31:0] prev_addr, rd_addr;
    int          lat;

    always @(posedge clk) begin
        if (tb_we) mem[tb_wa] <= tb_wd;
        if (!rst_n) begin
            mem_ready  <= 1'b0;
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            pend       <= 1'b0;
            prev_wait  <= 1'b0;
            prev_addr  <= '0;
            prev_write <= 1'b0;
            rd_addr    <= '0;
            lat        <= 0;
        end else begin
            mem_rvalid <= 1'b0;
            if (prev_wait && (!mem_valid || mem_addr != prev_addr || mem_write != prev_write))
                viol <= viol + 1;
            if (pend && mem_valid) viol <= viol + 1;
            if (mem_addr[1:0] != 2'b00 && mem_valid) viol <= viol + 1;
            prev_wait  <= mem_valid && !mem_ready;
            prev_addr  <= mem_addr;
            prev_write <= mem_write;
            if (mem_valid && mem_ready) begin
                if (mem_write) begin
                    mem[mem_addr[11:2]] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end else begin
                    pend    <= 1'b1;
                    lat     <= int'($urandom % 3);
                    rd_addr <= mem_addr;
                    rd_log[rd_cnt % 256] <= mem_addr;
                    rd_cnt  <= rd_cnt + 1;
                end
            end
            if (pend) begin
                if (lat == 0) begin
                    mem_rvalid <= 1'b1;
                    mem_rdata  <= mem[rd_addr[11:2]];
                    pend       <= 1'b0;
                end else begin
                    lat <= lat - 1;
                end
            end
            mem_ready <= ($urandom % 4) != 0;
        end
    end

    int n_chk = 0, n_err = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'h5A3C_0000 ^ (a * 32'h0001_0003);
    endfunction

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        tb_we = 1'b1; tb_wa = a[11:2]; tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input logic [31:0] b, input logic [31:0] info,
                            input logic [31:0] s, input logic [31:0] d,
                            input logic [31:0] len, input logic [31:0] strd,
                            input logic [31:0] nxt);
        poke(b, info); poke(b + 4, s); poke(b + 8, d);
        poke(b + 12, len); poke(b + 16, strd); poke(b + 20, nxt);
    endtask

    int irq_hi, end_hi;

    task automatic run_desc(input logic [31:0] a, input int mid_at,
                            input logic [31:0] mid_a, input int drop_at);
        int cyc;
        irq_hi = 0; end_hi = 0;
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!halted && cyc < 20000) begin
            if (irq) irq_hi++;
            if (end_flag) end_hi++;
            cyc++;
            if (cyc == mid_at) begin start = 1'b1; start_addr = mid_a; end
            if (cyc == mid_at + 1) start = 1'b0;
            if (cyc == drop_at) enable = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        chk("R11 run ends (halted)", {31'b0, halted}, 32'd1);
        chk("R11 active low at end", {31'b0, active}, 32'd0);
    endtask

    task automatic clear_flags();
        end_clr = 1'b1; int_clr = 1'b1;
        @(negedge clk);
        end_clr = 1'b0; int_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 active", {31'b0, active}, 32'd0);
        chk("R1 halted", {31'b0, halted}, 32'd0);
        chk("R1 end_flag", {31'b0, end_flag}, 32'd0);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
    endtask

    // linear copy, fetch order
    task automatic t_linear();
        int r0, w0;
        for (int i = 0; i < 4; i++) poke(32'h400 + i*4, pat(32'h400 + i*4));
        put_desc(32'h100, 32'h0000_0110, 32'h400, 32'h600, 32'd16, 32'h0, 32'h0);
        r0 = rd_cnt; w0 = wr_cnt;
        run_desc(32'h100, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            chk("R2 descriptor word read order", rd_log[(r0 + i) % 256], 32'h100 + i*4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 linear read address", rd_log[(r0 + 6 + i) % 256], 32'h400 + i*4);
            chk("R3 linear copy data", mem[(32'h600 + i*4) >> 2], pat(32'h400 + i*4));
        end
        chk("R3 read count", rd_cnt - r0, 32'd10);
        chk("R3 write count", wr_cnt - w0, 32'd4);
        chk("R3 final source", cur_src, 32'h410);
        chk("R3 final destination", cur_dst, 32'h610);
        chk("R8 linear length drained", cur_len, 32'h0);
        chk("R9 end flag set", {31'b0, end_flag}, 32'd1);
        chk("R9 irq stays low without bit 0", {31'b0, irq}, 32'd0);
        chk("R10 link zero stops chain", cur_desc, 32'h0);
    endtask

    // 2D with signed steps and interrupt
    task automatic t_2d();
        logic [31:0] srcs [0:5];
        logic [31:0] dsts [0:5];
        srcs = '{32'h800, 32'h804, 32'h810, 32'h814, 32'h820, 32'h824};
        dsts = '{32'hA00, 32'hA04, 32'h9F8, 32'h9FC, 32'h9F0, 32'h9F4};
        for (int i = 0; i < 6; i++) poke(srcs[i], pat(srcs[i]));
        clear_flags();
        put_desc(32'h120, 32'h0000_0113, 32'h800, 32'hA00, 32'h0003_0008,
                 32'hFFF0_0008, 32'h0);
        run_desc(32'h120, 0, 0, 0);
        for (int i = 0; i < 6; i++)
            chk("R4 R5 2D block placement", mem[dsts[i] >> 2], pat(srcs[i]));
        chk("R5 source after rows (no step after last)", cur_src, 32'h828);
        chk("R5 negative destination step", cur_dst, 32'h9F8);
        chk("R8 2D live length", cur_len, 32'h0001_0000);
        chk("R9 irq set by bit 0", {31'b0, irq}, 32'd1);
        chk("R9 end flag set", {31'b0, end_flag}, 32'd1);
        int_clr = 1'b1; @(negedge clk); int_clr = 1'b0;
        chk("R9 int_clr clears irq", {31'b0, irq}, 32'd0);
        chk("R9 int_clr leaves end flag", {31'b0, end_flag}, 32'd1);
        end_clr = 1'b1; @(negedge clk); end_clr = 1'b0;
        chk("R9 end_clr clears end flag", {31'b0, end_flag}, 32'd0);
    endtask

    // skip modes and a two-descriptor chain
    task automatic t_skip_chain();
        int r0, w0;
        poke(32'hC00, 32'hDEAD_0001); poke(32'hC04, 32'hDEAD_0002);
        for (int i = 0; i < 3; i++) begin
            poke(32'hD00 + i*4, 32'hBEEF_0000 + i);
            poke(32'h400 + i*4, pat(32'h400 + i*4));
        end
        put_desc(32'h140, 32'h0000_0810, 32'h0, 32'hC00, 32'd8, 32'h0, 32'h180);
        put_desc(32'h180, 32'h0000_0191, 32'h400, 32'hD00, 32'd12, 32'h0, 32'h0);
        clear_flags();
        r0 = rd_cnt; w0 = wr_cnt;
        run_desc(32'h140, 0, 0, 0);
        chk("R6 skipped source writes zero", mem[32'hC00 >> 2], 32'h0);
        chk("R6 skipped source writes zero", mem[32'hC04 >> 2], 32'h0);
        for (int i = 0; i < 3; i++)
            chk("R7 skipped destination untouched", mem[(32'hD00 + i*4) >> 2], 32'hBEEF_0000 + i);
        chk("R6 R7 read count", rd_cnt - r0, 32'd15);
        chk("R6 R7 write count", wr_cnt - w0, 32'd2);
        chk("R7 destination still advances", cur_dst, 32'hD0C);
        chk("R10 chain followed link", cur_src, 32'h40C);
        chk("R10 chain ended at zero link", cur_desc, 32'h0);
        chk("R9 irq from second descriptor", {31'b0, irq}, 32'd1);
    endtask

    // enable handling
    task automatic t_enable();
        int r0, w0;
        poke(32'hE00, 32'h0);
        put_desc(32'h1C0, 32'h0000_0110, 32'h400, 32'hE00, 32'd4, 32'h0, 32'h100);
        enable = 1'b0;
        r0 = rd_cnt;
        run_desc(32'h1C0, 0, 0, 0);
        chk("R11 disabled start moves nothing", rd_cnt - r0, 32'd0);
        chk("R11 disabled start keeps address", cur_desc, 32'h1C0);
        enable = 1'b1;
        r0 = rd_cnt; w0 = wr_cnt;
        run_desc(32'h1C0, 0, 0, 3);
        enable = 1'b1;
        chk("R10 enable low stops at boundary (reads)", rd_cnt - r0, 32'd7);
        chk("R10 enable low stops at boundary (writes)", wr_cnt - w0, 32'd1);
        chk("R10 link loaded but not fetched", cur_desc, 32'h100);
        chk("R10 first descriptor completed", mem[32'hE00 >> 2], pat(32'h400));
    endtask

    // zero rows, zero start address
    task automatic t_zero();
        int r0, w0;
        clear_flags();
        put_desc(32'h200, 32'h0000_0003, 32'h400, 32'hF00, 32'h0000_0010, 32'h0, 32'h0);
        r0 = rd_cnt; w0 = wr_cnt;
        run_desc(32'h200, 0, 0, 0);
        chk("R4 zero rows: fetch only", rd_cnt - r0, 32'd6);
        chk("R4 zero rows: no writes", wr_cnt - w0, 32'd0);
        chk("R8 zero rows leaves length", cur_len, 32'h0000_0010);
        chk("R9 zero-row descriptor still ends", {31'b0, end_flag}, 32'd1);
        clear_flags();
        r0 = rd_cnt;
        run_desc(32'h0, 0, 0, 0);
        chk("R11 zero start address moves nothing", rd_cnt - r0, 32'd0);
        chk("R11 zero start sets no end flag", {31'b0, end_flag}, 32'd0);
    endtask

    // completion coinciding with held clears
    task automatic t_set_vs_clear();
        end_clr = 1'b1; int_clr = 1'b1;
        @(negedge clk);
        run_desc(32'h120, 0, 0, 0);
        end_clr = 1'b0; int_clr = 1'b0;
        chk("R9 irq set wins over clear (one cycle)", irq_hi, 32'd1);
        chk("R9 end set wins over clear (one cycle)", end_hi, 32'd1);
        chk("R9 held clear removes irq afterwards", {31'b0, irq}, 32'd0);
    endtask

    // start while active
    task automatic t_restart_ignored();
        int r0;
        r0 = rd_cnt;
        run_desc(32'h100, 4, 32'h200, 0);
        chk("R11 start while active ignored (reads)", rd_cnt - r0, 32'd10);
        chk("R11 start while active ignored (source)", cur_src, 32'h410);
        chk("R12 handshake violations", viol, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_linear();
        t_2d();
        t_skip_chain();
        t_enable();
        t_zero();
        t_set_vs_clear();
        t_restart_ignored();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule